// File: doc/BRIEF.md
# Dual Character FIFO with DMA and Polled Servicing

This block holds characters in both directions between a UART serial core and a host. Bytes coming out of the deserializer collect in a receive FIFO. Bytes the host writes collect in a transmit FIFO, which the serializer then drains. The host can poll status flags to service either FIFO. It can also treat the request outputs as interrupt or DMA requests. In DMA use, the existing read and write strobes act as the acknowledge. Each direction is serviced on its own terms, so one side can be polled while the other uses DMA.

The receive request rises when the receive occupancy reaches a selectable trigger level. It also rises for leftover bytes below that level once the line has been quiet for a fixed number of character times. A character-time tick input measures that quiet time. Occupancy counts for both FIFOs are outputs, so a DMA engine can size its transfers. When FIFO mode is off, each direction behaves as a single holding register.

Top module: `uart_dual_fifo`

## Requirements
- R1: Each FIFO holds up to 64 eight-bit characters and returns them in arrival order. `rx_count` and `tx_count` report the occupancy, from 0 to 64.
- R2: When `fifo_en` is 0, the capacity of each direction is 1 entry. When `fifo_en` is 1, the capacity is 64.
- R3: `rx_data_ready` is 1 exactly when `rx_count` is at least 1.
- R4: `tx_need_data` is 1 exactly when `tx_count` is 0. `ser_tx_valid` is 1 exactly when `tx_count` is nonzero, and `ser_tx_data` shows the oldest transmit character.
- R5: The trigger select `rx_trig_sel` maps as follows: 2'b00 gives 1, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 56. When `fifo_en` is 0 the trigger is 1. `rx_dma_req` is 1 whenever `rx_count` is at or above the trigger.
- R6: An idle counter increments on each `char_tick` pulse, saturates at 4, and clears on every `rx_strobe`. When the counter is at 4 and `rx_count` is between 1 and trigger-1, `rx_dma_req` is 1.
- R7: A `host_tx_wr` to a full transmit FIFO leaves both its contents and its count unchanged.
- R8: An `rx_strobe` while the receive FIFO is full drops the character and sets `rx_overrun`. The flag stays set until a `status_rd` pulse clears it. If a new overrun occurs in the same cycle as `status_rd`, the flag stays 1.
- R9: `tx_dma_req` is 1 when `fifo_en` is 1 and 64 - `tx_count` is at least 32. When `fifo_en` is 0, it is 1 when `tx_count` is 0.
- R10: After reset, both FIFOs are empty, `rx_overrun` is 0, and the idle counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 64-entry FIFOs, 0 = single holding register per direction |
| rx_trig_sel | input | 2 | Receive trigger select |
| char_tick | input | 1 | One pulse per character time |
| rx_strobe | input | 1 | Received character valid from the deserializer |
| rx_data | input | 8 | Received character |
| host_rx_rd | input | 1 | Host or DMA pops the receive FIFO |
| host_rx_data | output | 8 | Oldest receive character |
| host_tx_wr | input | 1 | Host or DMA pushes into the transmit FIFO |
| host_tx_data | input | 8 | Character to transmit |
| ser_tx_take | input | 1 | Serializer pops the transmit FIFO |
| ser_tx_data | output | 8 | Oldest transmit character |
| ser_tx_valid | output | 1 | Transmit FIFO not empty |
| status_rd | input | 1 | Status read; clears `rx_overrun` |
| rx_data_ready | output | 1 | Receive data available |
| tx_need_data | output | 1 | Transmit FIFO empty |
| rx_count | output | 7 | Receive occupancy |
| tx_count | output | 7 | Transmit occupancy |
| rx_dma_req | output | 1 | Receive service request |
| tx_dma_req | output | 1 | Transmit service request |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The assertions assume that the strobes and pops are single-cycle qualified events sampled at the clock. They also assume `fifo_en` is changed only while both FIFOs are empty, because the count bounds are stated against the active capacity. The bench follows these rules. It drives every strobe for exactly one cycle, starting just after a rising edge. It switches `fifo_en` only after draining both sides, and it pops only when its own model says data is present, except for one deliberate pop of an empty FIFO.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int CHAR_W     = 8;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int IDLE_CHARS = 4;

  typedef enum logic [1:0] {
    TRIG_ONE   = 2'b00,
    TRIG_QTR   = 2'b01,
    TRIG_HALF  = 2'b10,
    TRIG_NEAR  = 2'b11
  } trig_sel_e;

  // Receive trigger level in entries for a select code and mode.
  function automatic logic [CNT_W-1:0] trig_level(input logic [1:0] sel, input logic en);
    logic [CNT_W-1:0] lvl;
    case (trig_sel_e'(sel))
      TRIG_ONE:  lvl = CNT_W'(1);
      TRIG_QTR:  lvl = CNT_W'(FIFO_DEPTH / 4);
      TRIG_HALF: lvl = CNT_W'(FIFO_DEPTH / 2);
      default:   lvl = CNT_W'(FIFO_DEPTH - FIFO_DEPTH / 8);
    endcase
    return en ? lvl : CNT_W'(1);
  endfunction

  // Free entries left in a FIFO of the given capacity.
  function automatic logic [CNT_W-1:0] free_slots(input logic [CNT_W-1:0] cap,
                                                 input logic [CNT_W-1:0] cnt);
    return (cnt >= cap) ? '0 : cap - cnt;
  endfunction
endpackage

// File: rtl/char_fifo.sv
module char_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int LIMIT = 4,
  localparam int TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  input  logic tick,
  output logic expired
);
  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (activity)       cnt <= '0;
    else if (tick && !expired) cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/uart_dual_fifo.sv
module uart_dual_fifo
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int W     = CHAR_W,
  parameter int IDLE  = IDLE_CHARS,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    rx_trig_sel,
  input  logic          char_tick,
  input  logic          rx_strobe,
  input  logic [W-1:0]  rx_data,
  input  logic          host_rx_rd,
  output logic [W-1:0]  host_rx_data,
  input  logic          host_tx_wr,
  input  logic [W-1:0]  host_tx_data,
  input  logic          ser_tx_take,
  output logic [W-1:0]  ser_tx_data,
  output logic          ser_tx_valid,
  input  logic          status_rd,
  output logic          rx_data_ready,
  output logic          tx_need_data,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rx_dma_req,
  output logic          tx_dma_req,
  output logic          rx_overrun
);
  logic [CW-1:0] cap;
  logic [CW-1:0] trig;
  logic          rx_full, rx_empty, rx_push_ok, rx_pop_ok;
  logic          tx_full, tx_empty, tx_push_ok, tx_pop_ok;
  logic          idle_expired;
  logic          rx_at_trig, rx_trail, rx_drop;

  assign cap  = fifo_en ? CW'(DEPTH) : CW'(1);
  assign trig = trig_level(rx_trig_sel, fifo_en);

  char_fifo #(.DEPTH(DEPTH), .W(W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .cap(cap),
    .push(rx_strobe), .din(rx_data), .pop(host_rx_rd), .dout(host_rx_data),
    .count(rx_count), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  char_fifo #(.DEPTH(DEPTH), .W(W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .cap(cap),
    .push(host_tx_wr), .din(host_tx_data), .pop(ser_tx_take), .dout(ser_tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  rx_idle_timer #(.LIMIT(IDLE)) u_idle (
    .clk(clk), .rst_n(rst_n), .activity(rx_strobe), .tick(char_tick),
    .expired(idle_expired)
  );

  assign rx_at_trig = (rx_count >= trig);
  assign rx_trail   = idle_expired && !rx_empty && (rx_count < trig);
  assign rx_dma_req = rx_at_trig || rx_trail;
  assign rx_drop    = rx_strobe && rx_full;

  assign rx_data_ready = !rx_empty;
  assign tx_need_data  = tx_empty;
  assign ser_tx_valid  = !tx_empty;
  assign tx_dma_req    = fifo_en ? (free_slots(cap, tx_count) >= CW'(DEPTH / 2)) : tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_overrun <= 1'b0;
    else if (rx_drop)   rx_overrun <= 1'b1;
    else if (status_rd) rx_overrun <= 1'b0;
  end
endmodule

// File: rtl/uart_dual_fifo_chk.sv
module uart_dual_fifo_chk #(
  parameter int CW = 7,
  parameter int DEPTH = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          rx_strobe,
  input logic          host_tx_wr,
  input logic          ser_tx_take,
  input logic          status_rd,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_overrun,
  input logic          tx_dma_req,
  input logic          rx_full,
  input logic          tx_full,
  input logic          rx_push_ok,
  input logic          rx_pop_ok,
  input logic          tx_push_ok,
  input logic          tx_pop_ok
);
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  // R1
  rx_push_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_ok && !rx_pop_ok) |=> (rx_count == $past(rx_count) + CW'(1)));

  // R1
  tx_pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop_ok && !tx_push_ok) |=> (tx_count == $past(tx_count) - CW'(1)));

  // R7
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && host_tx_wr && !ser_tx_take) |=> (tx_count == $past(tx_count)));

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && rx_full) |=> rx_overrun);

  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !status_rd) |=> rx_overrun);

  // R9
  tx_dma_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_req && fifo_en) |-> (tx_count <= CW'(DEPTH / 2)));
endmodule

bind uart_dual_fifo uart_dual_fifo_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_strobe(rx_strobe),
  .host_tx_wr(host_tx_wr), .ser_tx_take(ser_tx_take), .status_rd(status_rd),
  .rx_count(rx_count), .tx_count(tx_count), .rx_overrun(rx_overrun),
  .tx_dma_req(tx_dma_req), .rx_full(rx_full), .tx_full(tx_full),
  .rx_push_ok(rx_push_ok), .rx_pop_ok(rx_pop_ok),
  .tx_push_ok(tx_push_ok), .tx_pop_ok(tx_pop_ok)
);

// File: tb/uart_dual_fifo_bench.sv
module uart_dual_fifo_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic [1:0] rx_trig_sel = 2'b00;
  logic       char_tick = 1'b0, rx_strobe = 1'b0, host_rx_rd = 1'b0;
  logic       host_tx_wr = 1'b0, ser_tx_take = 1'b0, status_rd = 1'b0;
  logic [7:0] rx_data = '0, host_tx_data = '0;
  logic [7:0] host_rx_data, ser_tx_data;
  logic       ser_tx_valid, rx_data_ready, tx_need_data;
  logic       rx_dma_req, tx_dma_req, rx_overrun;
  logic [6:0] rx_count, tx_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] rxq[$];

  always #5 clk = ~clk;

  uart_dual_fifo u_uart_dual_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_trig_sel(rx_trig_sel),
    .char_tick(char_tick), .rx_strobe(rx_strobe), .rx_data(rx_data),
    .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .ser_tx_take(ser_tx_take), .ser_tx_data(ser_tx_data), .ser_tx_valid(ser_tx_valid),
    .status_rd(status_rd), .rx_data_ready(rx_data_ready), .tx_need_data(tx_need_data),
    .rx_count(rx_count), .tx_count(tx_count), .rx_dma_req(rx_dma_req),
    .tx_dma_req(tx_dma_req), .rx_overrun(rx_overrun)
  );

  // Transmit vectors: {wr, take, data[7:0], exp_count[6:0], exp_head[7:0]}
  localparam logic [24:0] TXV [8] = '{
    {1'b1, 1'b0, 8'hA1, 7'd1, 8'hA1},
    {1'b1, 1'b0, 8'hB2, 7'd2, 8'hA1},
    {1'b1, 1'b1, 8'hC3, 7'd2, 8'hB2},
    {1'b0, 1'b1, 8'h00, 7'd1, 8'hC3},
    {1'b0, 1'b1, 8'h00, 7'd0, 8'h00},
    {1'b1, 1'b0, 8'h5A, 7'd1, 8'h5A},
    {1'b0, 1'b1, 8'h00, 7'd0, 8'h00},
    {1'b0, 1'b1, 8'h00, 7'd0, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_strobe = 1'b1; rx_data = d;
    if (rxq.size() < (fifo_en ? 64 : 1)) rxq.push_back(d);
    cyc();
    rx_strobe = 1'b0;
  endtask

  task automatic rx_pop_chk(input string req);
    logic [7:0] e;
    e = rxq.pop_front();
    chk(host_rx_data == e, req, host_rx_data, e);
    host_rx_rd = 1'b1; cyc(); host_rx_rd = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    host_tx_wr = 1'b1; host_tx_data = d; cyc(); host_tx_wr = 1'b0;
  endtask

  task automatic ctick();
    char_tick = 1'b1; cyc(); char_tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();

    // R10 reset state, R3 R4 R9 flags
    chk(rx_count == 0 && tx_count == 0, "R10", rx_count, 0);
    chk(!rx_overrun && !rx_dma_req, "R10", rx_overrun, 0);
    chk(!rx_data_ready, "R3", rx_data_ready, 0);
    chk(tx_need_data && !ser_tx_valid, "R4", tx_need_data, 1);
    chk(tx_dma_req, "R9", tx_dma_req, 1);

    // R1 R4 transmit vector table
    foreach (TXV[i]) begin
      host_tx_wr = TXV[i][24]; ser_tx_take = TXV[i][23]; host_tx_data = TXV[i][22:15];
      cyc();
      host_tx_wr = 1'b0; ser_tx_take = 1'b0;
      chk(tx_count == TXV[i][14:8], "R1", tx_count, TXV[i][14:8]);
      chk(ser_tx_valid == (TXV[i][14:8] != 0), "R4", ser_tx_valid, TXV[i][14:8] != 0);
      if (TXV[i][14:8] != 0) chk(ser_tx_data == TXV[i][7:0], "R4", ser_tx_data, TXV[i][7:0]);
    end

    // R5 trigger 16
    rx_trig_sel = 2'b01;
    for (int i = 0; i < 15; i++) rx_push(8'(i + 8'h10));
    chk(!rx_dma_req, "R5", rx_dma_req, 0);
    chk(rx_data_ready, "R3", rx_data_ready, 1);
    rx_push(8'h1F);
    chk(rx_dma_req, "R5", rx_dma_req, 1);
    for (int i = 0; i < 16; i++) rx_pop_chk("R1");
    chk(rx_count == 0 && !rx_data_ready, "R3", rx_count, 0);

    // R6 trailing bytes
    for (int i = 0; i < 3; i++) rx_push(8'(8'h40 + i));
    for (int i = 0; i < 3; i++) ctick();
    chk(!rx_dma_req, "R6", rx_dma_req, 0);
    ctick();
    chk(rx_dma_req, "R6", rx_dma_req, 1);
    rx_push(8'h43);
    chk(!rx_dma_req && rx_count == 4, "R6", rx_dma_req, 0);
    for (int i = 0; i < 4; i++) rx_pop_chk("R6");

    // R5 trigger 56 and 32
    rx_trig_sel = 2'b11;
    for (int i = 0; i < 55; i++) rx_push(8'(i + 8'h80));
    chk(!rx_dma_req, "R5", rx_dma_req, 0);
    rx_push(8'hB7);
    chk(rx_dma_req, "R5", rx_dma_req, 1);
    rx_trig_sel = 2'b10;
    for (int i = 0; i < 24; i++) rx_pop_chk("R1");
    chk(rx_dma_req && rx_count == 32, "R5", rx_count, 32);
    rx_pop_chk("R1");
    chk(!rx_dma_req, "R5", rx_dma_req, 0);

    // R8 overrun at full
    for (int i = 0; i < 33; i++) rx_push(8'(i + 8'h20));
    chk(rx_count == 64 && !rx_overrun, "R1", rx_count, 64);
    rx_push(8'hEE);
    chk(rx_overrun && rx_count == 64, "R8", rx_overrun, 1);
    cyc();
    chk(rx_overrun, "R8", rx_overrun, 1);
    status_rd = 1'b1; cyc(); status_rd = 1'b0;
    chk(!rx_overrun, "R8", rx_overrun, 0);
    rx_strobe = 1'b1; rx_data = 8'hEF; status_rd = 1'b1; cyc();
    rx_strobe = 1'b0; status_rd = 1'b0;
    chk(rx_overrun, "R8", rx_overrun, 1);
    while (rxq.size() > 0) rx_pop_chk("R8");
    chk(rx_count == 0, "R8", rx_count, 0);

    // R9 transmit request by free space, R7 full write ignored
    for (int i = 0; i < 32; i++) tx_push(8'(i));
    chk(tx_dma_req, "R9", tx_dma_req, 1);
    tx_push(8'd32);
    chk(!tx_dma_req, "R9", tx_dma_req, 0);
    for (int i = 33; i < 64; i++) tx_push(8'(i));
    tx_push(8'hFF);
    chk(tx_count == 64, "R7", tx_count, 64);
    for (int i = 0; i < 64; i++) begin
      chk(ser_tx_data == 8'(i), "R7", ser_tx_data, i);
      ser_tx_take = 1'b1; cyc(); ser_tx_take = 1'b0;
    end
    chk(tx_need_data && tx_count == 0, "R7", tx_count, 0);

    // R2 holding-register mode
    fifo_en = 1'b0; rx_trig_sel = 2'b11;
    status_rd = 1'b1; cyc(); status_rd = 1'b0;
    tx_push(8'h31); tx_push(8'h32);
    chk(tx_count == 1 && ser_tx_data == 8'h31, "R2", tx_count, 1);
    chk(!tx_dma_req, "R9", tx_dma_req, 0);
    rx_push(8'h61);
    chk(rx_dma_req, "R5", rx_dma_req, 1);
    rx_push(8'h62);
    chk(rx_count == 1 && rx_overrun, "R2", rx_count, 1);
    rx_pop_chk("R2");
    ser_tx_take = 1'b1; cyc(); ser_tx_take = 1'b0;
    chk(tx_dma_req, "R9", tx_dma_req, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule